// File: doc/BRIEF.md
# Complex Lag Correlator Slice with Fringe Rotation

This block cross-correlates two quantized sample streams over eight complex lags. The delayed stream is taken from one of four source channels and multiplied by a three-level cosine and sine fringe phase. The two rotated components are pushed into a tapped delay line. On every multiply-enabled cycle, each lag multiplies its tap by the undelayed reference sample. The result feeds two tallies per lag, one for the real (cosine) path and one for the imaginary (sine) path.

Each tally adds an offset increment of product+1, which is 0, 1 or 2. The increment goes into a 2-bit prescaler whose carry drives a 16-bit counter. A dump strobe moves every counter into its readout register and restarts counting in the same cycle. A product is dropped whenever a sample or the phase carries the invalid code. Lag spacing can be one sample, or two samples when the oversampling mode is on. All taps can also be moved by one sample either way with the vernier setting.

Top module: `corr_lag_array`

## Requirements
- R1: Sample codes decode as follows. In 3-level mode 00=0, 01=+1 and 11=-1. In 2-level mode 00 and 01 both mean +1 and 11=-1. In both modes 10 is invalid.
- R2: The delayed stream is channel `src_sel_i` of `src_i`, taken from bits [2*sel+1:2*sel].
- R3: The stored real component is x·cos and the stored imaginary component is x·sin. Phase codes are 00=0, 01=+1 and 11=-1, and 10 marks an invalid phase.
- R4: Tap slot 0 holds the most recently shifted sample. Lag k reads slot base+k·step. The base comes from `vernier_i`: 01 gives 2, 11 gives 0, and 00 or 10 gives 1.
- R5: The lag step is 1 when `oversample_i`=0 and 2 when it is 1.
- R6: A product is not accumulated if the tap sample is invalid, the reference sample is invalid, or either phase value was invalid.
- R7: Each valid product p adds p+1 to a 2-bit prescaler. The readout value is floor(total/4) mod 2^16.
- R8: The readout takes the count including the dump cycle's product. The prescaler and counter restart from zero in the same cycle. The readout holds until the next dump.
- R9: With `shift_en_i` low the delay line holds its contents. With `mult_en_i` low no product is accumulated.
- R10: After reset every readout is zero and every tap slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| three_level_i | input | 1 | 1 = 3-level decoding, 0 = 2-level |
| oversample_i | input | 1 | 1 = two-sample lag spacing |
| vernier_i | input | 2 | Tap offset code |
| src_sel_i | input | 2 | Source channel select |
| src_i | input | 8 | Four 2-bit source channels |
| ref_i | input | 2 | Undelayed reference sample |
| cos_i | input | 2 | Cosine phase code |
| sin_i | input | 2 | Sine phase code |
| shift_en_i | input | 1 | Delay line advance enable |
| mult_en_i | input | 1 | Accumulate enable |
| dump_i | input | 1 | Readout and restart strobe |
| rd_re_o | output | 128 | Real readouts, lag k at [16k+15:16k] |
| rd_im_o | output | 128 | Imaginary readouts, lag k at [16k+15:16k] |

## Verification
The assertions check the following on every cycle:
- The delay line holds or shifts by exactly one slot, depending on the shift enable.
- A tally never changes while idle or on an invalid product.
- A tally steps by at most two per product.
- A dump clears the counters, and the readout changes only on a dump.

Correct decoding in both quantizer modes, the phase products, channel selection, and tap placement under each vernier and spacing setting can only be shown by the bench. Its behavioural model compares every readout on every clock over random streams that contain invalid codes.

// File: rtl/corr_pkg.sv
package corr_pkg;

    // Ternary value with validity: val is -1, 0 or +1 as 2-bit signed
    typedef struct packed {
        logic              ok;
        logic signed [1:0] val;
    } tern_t;

    localparam logic [1:0] CODE_BAD = 2'b10;

    // Sample code: 10 invalid, 11 -1, 01 +1, 00 is 0 (3-level) or +1 (2-level)
    function automatic tern_t dec_sample(input logic [1:0] code, input logic three);
        tern_t t;
        case (code)
            2'b10:   begin t.ok = 1'b0; t.val = 2'sb00; end
            2'b11:   begin t.ok = 1'b1; t.val = 2'sb11; end
            2'b01:   begin t.ok = 1'b1; t.val = 2'sb01; end
            default: begin t.ok = 1'b1; t.val = three ? 2'sb00 : 2'sb01; end
        endcase
        return t;
    endfunction

    // Phase code: 10 invalid, 11 -1, 01 +1, 00 zero
    function automatic tern_t dec_phase(input logic [1:0] code);
        tern_t t;
        case (code)
            2'b10:   begin t.ok = 1'b0; t.val = 2'sb00; end
            2'b11:   begin t.ok = 1'b1; t.val = 2'sb11; end
            2'b01:   begin t.ok = 1'b1; t.val = 2'sb01; end
            default: begin t.ok = 1'b1; t.val = 2'sb00; end
        endcase
        return t;
    endfunction

    // Product of two ternary values; valid only if both are valid
    function automatic tern_t tern_mul(input tern_t a, input tern_t b);
        tern_t t;
        t.ok = a.ok & b.ok;
        if (a.val == 2'sb00 || b.val == 2'sb00) t.val = 2'sb00;
        else if (a.val == b.val)                t.val = 2'sb01;
        else                                    t.val = 2'sb11;
        return t;
    endfunction

endpackage

// File: rtl/corr_rotator.sv
module corr_rotator
    import corr_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int SEL_W = $clog2(N_SRC)
) (
    input  logic [2*N_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               three_i,
    input  logic [1:0]         cos_i,
    input  logic [1:0]         sin_i,
    output tern_t              rot_re_o,
    output tern_t              rot_im_o
);

    logic [1:0] code_sel;
    tern_t      x_t, c_t, s_t;
    logic       all_ok;

    always_comb begin
        code_sel = src_i[2*sel_i +: 2];
        x_t      = dec_sample(code_sel, three_i);
        c_t      = dec_phase(cos_i);
        s_t      = dec_phase(sin_i);
        all_ok   = x_t.ok & c_t.ok & s_t.ok;
        rot_re_o = tern_mul(x_t, c_t);
        rot_im_o = tern_mul(x_t, s_t);
        rot_re_o.ok = all_ok;
        rot_im_o.ok = all_ok;
    end

endmodule

// File: rtl/corr_delay_line.sv
module corr_delay_line
    import corr_pkg::*;
#(
    parameter int DEPTH = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en_i,
    input  tern_t               din_re_i,
    input  tern_t               din_im_i,
    output tern_t [DEPTH-1:0]   tap_re_o,
    output tern_t [DEPTH-1:0]   tap_im_o
);

    typedef struct packed {
        tern_t [DEPTH-1:0] re;
        tern_t [DEPTH-1:0] im;
    } line_t;

    line_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (shift_en_i) begin
            state_d.re = {state_q.re[DEPTH-2:0], din_re_i};
            state_d.im = {state_q.im[DEPTH-2:0], din_im_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tap_re_o = state_q.re;
    assign tap_im_o = state_q.im;

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |=> $stable(state_q));

    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> (state_q.re[1] == $past(state_q.re[0]) &&
                        state_q.im[1] == $past(state_q.im[0])));

endmodule

// File: rtl/corr_tally.sv
module corr_tally
    import corr_pkg::*;
#(
    parameter int PRE_W = 2,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             dump_i,
    input  tern_t            prod_i,
    output logic [CNT_W-1:0] rd_o
);

    localparam int TOT_W = PRE_W + CNT_W;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rd;
    } tally_t;

    tally_t           state_d, state_q;
    logic [1:0]       inc;
    logic [PRE_W:0]   sum;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        inc = 2'd0;
        if (en_i && prod_i.ok) begin
            case (prod_i.val)
                2'sb11:  inc = 2'd0;
                2'sb01:  inc = 2'd2;
                default: inc = 2'd1;
            endcase
        end
        sum      = {1'b0, state_q.pre} + (PRE_W+1)'(inc);
        cnt_next = state_q.cnt + CNT_W'(sum[PRE_W]);
        state_d  = state_q;
        if (dump_i) begin
            state_d.rd  = cnt_next;
            state_d.pre = '0;
            state_d.cnt = '0;
        end else begin
            state_d.pre = sum[PRE_W-1:0];
            state_d.cnt = cnt_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_o = state_q.rd;

    logic [TOT_W-1:0] tot_q;
    assign tot_q = {state_q.cnt, state_q.pre};

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !dump_i) |=> $stable(tot_q));

    p_skip_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!prod_i.ok && !dump_i) |=> $stable(tot_q));

    p_step_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !dump_i) |=> (TOT_W'(tot_q - $past(tot_q)) <= TOT_W'(2)));

    p_dump_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dump_i |=> (tot_q == '0));

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dump_i |=> $stable(rd_o));

endmodule

// File: rtl/corr_lag_array.sv
module corr_lag_array
    import corr_pkg::*;
#(
    parameter int LAGS  = 8,
    parameter int N_SRC = 4,
    parameter int PRE_W = 2,
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  three_level_i,
    input  logic                  oversample_i,
    input  logic [1:0]            vernier_i,
    input  logic [1:0]            src_sel_i,
    input  logic [2*N_SRC-1:0]    src_i,
    input  logic [1:0]            ref_i,
    input  logic [1:0]            cos_i,
    input  logic [1:0]            sin_i,
    input  logic                  shift_en_i,
    input  logic                  mult_en_i,
    input  logic                  dump_i,
    output logic [LAGS*CNT_W-1:0] rd_re_o,
    output logic [LAGS*CNT_W-1:0] rd_im_o
);

    localparam int DEPTH = 2 * LAGS + 1;
    localparam int IDX_W = $clog2(DEPTH);

    tern_t             rot_re, rot_im, ref_t;
    tern_t [DEPTH-1:0] tap_re, tap_im;
    logic [IDX_W-1:0]  base;

    corr_rotator #(.N_SRC(N_SRC), .SEL_W(2)) u_rot (
        .src_i    (src_i),
        .sel_i    (src_sel_i),
        .three_i  (three_level_i),
        .cos_i    (cos_i),
        .sin_i    (sin_i),
        .rot_re_o (rot_re),
        .rot_im_o (rot_im)
    );

    corr_delay_line #(.DEPTH(DEPTH)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en_i),
        .din_re_i   (rot_re),
        .din_im_i   (rot_im),
        .tap_re_o   (tap_re),
        .tap_im_o   (tap_im)
    );

    always_comb begin
        ref_t = dec_sample(ref_i, three_level_i);
        case (vernier_i)
            2'b01:   base = IDX_W'(2);
            2'b11:   base = IDX_W'(0);
            default: base = IDX_W'(1);
        endcase
    end

    for (genvar k = 0; k < LAGS; k++) begin : g_lag
        logic [IDX_W-1:0] idx;
        tern_t            prod_re, prod_im;

        always_comb begin
            idx     = base + IDX_W'(k) * (oversample_i ? IDX_W'(2) : IDX_W'(1));
            prod_re = tern_mul(tap_re[idx], ref_t);
            prod_im = tern_mul(tap_im[idx], ref_t);
        end

        corr_tally #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_re (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (mult_en_i),
            .dump_i (dump_i),
            .prod_i (prod_re),
            .rd_o   (rd_re_o[k*CNT_W +: CNT_W])
        );

        corr_tally #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_im (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (mult_en_i),
            .dump_i (dump_i),
            .prod_i (prod_im),
            .rd_o   (rd_im_o[k*CNT_W +: CNT_W])
        );
    end

endmodule

// File: tb/test_corr_lag_array.sv
`timescale 1ns/1ps
module test_corr_lag_array;

    localparam int LAGS  = 8;
    localparam int CNT_W = 16;
    localparam int DEPTH = 2 * LAGS + 1;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  three_level_i, oversample_i;
    logic [1:0]            vernier_i, src_sel_i, ref_i, cos_i, sin_i;
    logic [7:0]            src_i;
    logic                  shift_en_i, mult_en_i, dump_i;
    logic [LAGS*CNT_W-1:0] rd_re_o, rd_im_o;

    always #2.5 clk = ~clk;

    corr_lag_array i_corr_lag_array (
        .clk(clk), .rst_n(rst_n), .three_level_i(three_level_i),
        .oversample_i(oversample_i), .vernier_i(vernier_i), .src_sel_i(src_sel_i),
        .src_i(src_i), .ref_i(ref_i), .cos_i(cos_i), .sin_i(sin_i),
        .shift_en_i(shift_en_i), .mult_en_i(mult_en_i), .dump_i(dump_i),
        .rd_re_o(rd_re_o), .rd_im_o(rd_im_o)
    );

    int total = 0;
    int bad   = 0;

    // Behavioural model state
    int m_re [DEPTH];
    int m_im [DEPTH];
    bit m_ok [DEPTH];
    int t_re [LAGS];
    int t_im [LAGS];
    int e_re [LAGS];
    int e_im [LAGS];

    task automatic dec(input logic [1:0] c, input bit three, input bit phase,
                       output int v, output bit ok);
        ok = 1'b1;
        if (c == 2'b10)      begin ok = 1'b0; v = 0; end
        else if (c == 2'b11) v = -1;
        else if (c == 2'b01) v = 1;
        else                 v = (three || phase) ? 0 : 1;
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin m_re[i] = 0; m_im[i] = 0; m_ok[i] = 0; end
        for (int k = 0; k < LAGS; k++) begin t_re[k] = 0; t_im[k] = 0; e_re[k] = 0; e_im[k] = 0; end
    endtask

    task automatic compare(input string tag);
        for (int k = 0; k < LAGS; k++) begin
            int gr, gi;
            gr = int'(rd_re_o[k*CNT_W +: CNT_W]);
            gi = int'(rd_im_o[k*CNT_W +: CNT_W]);
            total += 2;
            if (gr != e_re[k]) begin
                bad++;
                $display("FAIL %s lag %0d real: got %0d exp %0d", tag, k, gr, e_re[k]);
            end
            if (gi != e_im[k]) begin
                bad++;
                $display("FAIL %s lag %0d imag: got %0d exp %0d", tag, k, gi, e_im[k]);
            end
        end
    endtask

    // Apply one clock with the inputs already driven, update model, compare
    task automatic step(input string tag);
        int xv, cv, sv, yv, base, stp, d;
        bit xok, cok, sok, yok, rok;
        dec(src_i[2*src_sel_i +: 2], three_level_i, 1'b0, xv, xok);
        dec(cos_i, 1'b1, 1'b1, cv, cok);
        dec(sin_i, 1'b1, 1'b1, sv, sok);
        dec(ref_i, three_level_i, 1'b0, yv, yok);
        rok  = xok && cok && sok;
        base = (vernier_i == 2'b01) ? 2 : (vernier_i == 2'b11) ? 0 : 1;
        stp  = oversample_i ? 2 : 1;
        for (int k = 0; k < LAGS; k++) begin
            d = base + k * stp;
            if (mult_en_i && m_ok[d] && yok) begin
                t_re[k] += m_re[d] * yv + 1;
                t_im[k] += m_im[d] * yv + 1;
            end
            if (dump_i) begin
                e_re[k] = (t_re[k] >> 2) & 16'hFFFF;
                e_im[k] = (t_im[k] >> 2) & 16'hFFFF;
                t_re[k] = 0;
                t_im[k] = 0;
            end
        end
        if (shift_en_i) begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                m_re[i] = m_re[i-1]; m_im[i] = m_im[i-1]; m_ok[i] = m_ok[i-1];
            end
            m_re[0] = xv * cv; m_im[0] = xv * sv; m_ok[0] = rok;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [1:0] rnd_code(input int inv_pct);
        int r;
        if (int'($urandom_range(99)) < inv_pct) return 2'b10;
        r = int'($urandom_range(2));
        return (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
    endfunction

    // Negative knob values mean random per cycle; dump_every 0 dumps only at the end
    task automatic run(input string tag, input int n, input int three, input int os,
                       input int vc, input int sel, input int inv_pct,
                       input int shift_pct, input int mult_pct, input int dump_every);
        for (int c = 0; c < n; c++) begin
            three_level_i = (three < 0) ? 1'($urandom_range(1)) : 1'(three);
            oversample_i  = (os < 0) ? 1'($urandom_range(1)) : 1'(os);
            vernier_i     = (vc < 0) ? 2'($urandom_range(3)) : 2'(vc);
            src_sel_i     = (sel < 0) ? 2'($urandom_range(3)) : 2'(sel);
            for (int s = 0; s < 4; s++) src_i[2*s +: 2] = rnd_code(inv_pct);
            ref_i         = rnd_code(inv_pct);
            cos_i         = rnd_code(inv_pct / 3);
            sin_i         = rnd_code(inv_pct / 3);
            shift_en_i    = int'($urandom_range(99)) < shift_pct;
            mult_en_i     = int'($urandom_range(99)) < mult_pct;
            dump_i        = (dump_every == 0) ? (c == n - 1)
                                              : ((c % dump_every) == dump_every - 1);
            step(tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        three_level_i = 1'b1; oversample_i = 1'b0; vernier_i = 2'b00; src_sel_i = 2'b00;
        src_i = '0; ref_i = 2'b01; cos_i = 2'b01; sin_i = 2'b01;
        shift_en_i = 1'b0; mult_en_i = 1'b0; dump_i = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R10");      // R10: readouts zero in reset
        rst_n = 1'b1;
        // R10: slots start invalid, so accumulating without shifting yields zero
        run("R10", 12, 1, 0, 0, 0, 0, 0, 100, 6);
        // R1: both quantizer modes
        run("R1", 300, 0, 0, 0, 0, 0, 100, 100, 60);
        run("R1", 300, 1, 0, 0, 0, 0, 100, 100, 60);
        // R2: each source channel
        for (int s = 0; s < 4; s++) run("R2", 150, 1, 0, 0, s, 0, 100, 100, 50);
        // R3: random phases
        run("R3", 400, 1, 0, 0, 0, 0, 100, 100, 80);
        // R4: each vernier code
        run("R4", 200, 1, 0, 0, -1, 0, 100, 100, 40);
        run("R4", 200, 1, 0, 1, -1, 0, 100, 100, 40);
        run("R4", 200, 1, 0, 3, -1, 0, 100, 100, 40);
        run("R4", 200, 1, 0, 2, -1, 0, 100, 100, 40);
        // R5: two-sample lag spacing with vernier variations
        run("R5", 300, 1, 1, 0, 0, 0, 100, 100, 60);
        run("R5", 300, 0, 1, -1, -1, 0, 100, 100, 60);
        // R6: heavy invalid codes, everything random
        run("R6", 600, -1, -1, -1, -1, 30, 100, 100, 100);
        // R9: gated shift and multiply
        run("R9", 600, -1, -1, -1, -1, 10, 50, 50, 70);
        run("R9", 100, 1, 0, 0, 0, 0, 0, 0, 25);
        // R8: dump every cycle and every other cycle
        run("R8", 200, 1, 0, 0, 0, 5, 100, 100, 1);
        run("R8", 200, -1, 0, 0, -1, 5, 100, 100, 2);
        // R7: long accumulation through the prescaler
        run("R7", 3000, 1, 0, 0, 0, 0, 100, 100, 0);
        run("R7", 2000, 0, 0, 1, 2, 0, 100, 100, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule